// File: doc/BRIEF.md
# Data Cache Access Policy Controller

This block makes the per-access policy decision for a data cache. Each request carries its direction, whether it is an atomic operation (compare-and-swap or test-and-set), the page caching mode, and the tag lookup outcome (miss, clean hit or dirty hit). A global bus-lock input marks every access as locked while it is high. The block answers with one action code. That code tells the cache to serve a hit, allocate a line, skip allocation, go straight to the bus, invalidate the line, or push the dirty line and then invalidate it.

A 32-bit control word is written as a whole word and reads back with its reserved bits forced to zero. Four of its bits drive the policy: the enable, no-allocate, keep-after-push and half-capacity bits. When a locked access hits a dirty line, the block raises a push request and stalls. It issues the bypass for the operand only after the push is acknowledged. The tag and data arrays and the bus are outside the block.

Top module: `dcache_policy_ctl`

## Requirements
- R1: After synchronous reset the control word reads 0, and `act_valid`, `push_req` and `busy` are low. Reset touches no cache contents; the block has no port to them.
- R2: A write updates all implemented control bits at once. Only bits 31–27, 23–21 and 15–13 are stored. Every other bit reads back as zero.
- R3: With bit 31 clear, every accepted request returns action code 3 (bypass) and never raises `push_req`.
- R4: With bit 31 set, a locked miss returns code 3 (bypass). This holds for reads and writes, with bit 30 set or clear, and in any caching mode. A request is locked when `req_atomic` or `bus_lock` is high.
- R5: With bit 31 set, a locked hit on a clean line returns code 4 (invalidate, then bypass).
- R6: With bit 31 set, a locked hit on a dirty line returns code 5 (push then invalidate). `push_req` and `busy` then stay high until `push_ack`. The cycle after the acknowledge, `act_valid` shows code 3 for the same set. Requests offered while `busy` is high are not accepted.
- R7: With bit 31 set, an unlocked request behaves as follows. In a cache-inhibited page (`req_cacheable` low) it returns code 3. On a hit it returns code 0. On a miss it returns code 1 (allocate) when bit 30 is clear and code 2 (no allocate) when bit 30 is set.
- R8: `push_keep_valid` equals control bit 28 (1 = lines stay valid after an explicit push).
- R9: `half_mode` equals control bit 27. While it is set, the top bit of `act_set` is zero. Otherwise `act_set` repeats `req_set`.
- R10: `act_valid` pulses for exactly one cycle, one clock after a request is accepted. The decision uses the control word held in the cycle of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Write strobe for the control word |
| ctl_wr_data | input | 32 | Control word to write |
| ctl_rd_data | output | 32 | Current control word, reserved bits zero |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_atomic | input | 1 | Access belongs to an atomic read-modify-write |
| bus_lock | input | 1 | Global lock; every access is treated as locked |
| req_cacheable | input | 1 | 1 = cacheable page, 0 = cache-inhibited page |
| lookup_hit | input | 1 | Tag lookup hit |
| lookup_dirty | input | 1 | Hit line is dirty |
| req_set | input | SET_W | Set index from the address |
| busy | output | 1 | Waiting for a push acknowledge; no request is accepted |
| push_req | output | 1 | Push of the dirty line requested |
| push_ack | input | 1 | Push completed |
| act_valid | output | 1 | Action code valid |
| act_code | output | 3 | Action code (see R3–R7) |
| act_set | output | SET_W | Effective set index for the action |
| push_keep_valid | output | 1 | Pushed lines remain valid |
| half_mode | output | 1 | Half-capacity mode active |

## Verification
The hardest situation to reach is a request arriving during the push wait. To get there, the stimulus needs an enabled cache, a locked access and a dirty hit, and then must hold off the acknowledge. The bench creates a dirty locked hit and withholds `push_ack` for several cycles. During that window it offers a further unlocked miss. If the block accepted that miss, an allocate code would appear ahead of the expected bypass in the scoreboard. Only then does the bench acknowledge the push.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

    typedef enum logic [2:0] {
        ACT_HIT        = 3'd0,
        ACT_ALLOC      = 3'd1,
        ACT_NOALLOC    = 3'd2,
        ACT_BYPASS     = 3'd3,
        ACT_INVAL      = 3'd4,
        ACT_PUSH_INVAL = 3'd5
    } act_e;

    // Stored bits: 31..27, 23..21, 15..13
    localparam logic [31:0] CTL_KEEP_MASK = 32'hF8E0_E000;
    localparam int B_ENABLE  = 31;
    localparam int B_NOALLOC = 30;
    localparam int B_KEEP    = 28;
    localparam int B_HALF    = 27;

    typedef struct packed {
        logic write;
        logic locked;
        logic cacheable;
        logic hit;
        logic dirty;
    } access_t;

    function automatic act_e pick_action(input access_t a, input logic en,
                                         input logic no_alloc);
        act_e r;
        if (!en)                      r = ACT_BYPASS;
        else if (a.locked) begin
            if (!a.hit)               r = ACT_BYPASS;
            else if (a.dirty)         r = ACT_PUSH_INVAL;
            else                      r = ACT_INVAL;
        end
        else if (!a.cacheable)        r = ACT_BYPASS;
        else if (a.hit)               r = ACT_HIT;
        else if (no_alloc)            r = ACT_NOALLOC;
        else                          r = ACT_ALLOC;
        return r;
    endfunction

endpackage

// File: rtl/dcp_ctl_reg.sv
module dcp_ctl_reg
    import dcp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] value
);
    always_ff @(posedge clk) begin
        if (rst)        value <= '0;
        else if (wr_en) value <= wr_data & CTL_KEEP_MASK;
    end
endmodule

// File: rtl/dcp_seq.sv
module dcp_seq
    import dcp_pkg::*;
#(
    parameter int SET_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  act_e             dec,
    input  logic [SET_W-1:0] set_in,
    input  logic             push_ack,
    output logic             waiting,
    output logic             out_valid,
    output act_e             out_code,
    output logic [SET_W-1:0] out_set
);
    typedef enum logic {S_IDLE, S_WAIT} st_e;
    st_e st;

    assign waiting = (st == S_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            out_valid <= 1'b0;
            out_code  <= ACT_HIT;
            out_set   <= '0;
        end else begin
            out_valid <= 1'b0;
            if (st == S_WAIT) begin
                if (push_ack) begin
                    st        <= S_IDLE;
                    out_valid <= 1'b1;
                    out_code  <= ACT_BYPASS;
                end
            end else if (take) begin
                out_valid <= 1'b1;
                out_code  <= dec;
                out_set   <= set_in;
                if (dec == ACT_PUSH_INVAL) st <= S_WAIT;
            end
        end
    end
endmodule

// File: rtl/dcache_policy_ctl.sv
module dcache_policy_ctl
    import dcp_pkg::*;
#(
    parameter int SET_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr_en,
    input  logic [31:0]      ctl_wr_data,
    output logic [31:0]      ctl_rd_data,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_atomic,
    input  logic             bus_lock,
    input  logic             req_cacheable,
    input  logic             lookup_hit,
    input  logic             lookup_dirty,
    input  logic [SET_W-1:0] req_set,
    output logic             busy,
    output logic             push_req,
    input  logic             push_ack,
    output logic             act_valid,
    output logic [2:0]       act_code,
    output logic [SET_W-1:0] act_set,
    output logic             push_keep_valid,
    output logic             half_mode
);
    localparam int TOP = SET_W - 1;

    logic [31:0]      ctl;
    access_t          acc;
    act_e             dec;
    act_e             code_q;
    logic             waiting;
    logic [SET_W-1:0] set_eff;

    dcp_ctl_reg u_reg (
        .clk(clk), .rst(rst), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data), .value(ctl)
    );

    assign acc = '{write: req_write, locked: req_atomic | bus_lock,
                   cacheable: req_cacheable, hit: lookup_hit,
                   dirty: lookup_hit & lookup_dirty};
    assign dec = pick_action(acc, ctl[B_ENABLE], ctl[B_NOALLOC]);

    generate
        if (SET_W > 1) begin : g_fold
            assign set_eff = ctl[B_HALF] ? {1'b0, req_set[TOP-1:0]} : req_set;
        end else begin : g_single
            assign set_eff = ctl[B_HALF] ? 1'b0 : req_set;
        end
    endgenerate

    dcp_seq #(.SET_W(SET_W)) u_seq (
        .clk(clk), .rst(rst), .take(req_valid), .dec(dec), .set_in(set_eff),
        .push_ack(push_ack), .waiting(waiting), .out_valid(act_valid),
        .out_code(code_q), .out_set(act_set)
    );

    assign ctl_rd_data     = ctl;
    assign busy            = waiting;
    assign push_req        = waiting;
    assign act_code        = code_q;
    assign push_keep_valid = ctl[B_KEEP];
    assign half_mode       = ctl[B_HALF];
endmodule

// File: rtl/dcp_checker.sv
module dcp_checker
    import dcp_pkg::*;
#(
    parameter int SET_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic [31:0]      ctl_rd_data,
    input logic             req_valid,
    input logic             req_atomic,
    input logic             bus_lock,
    input logic             lookup_hit,
    input logic             busy,
    input logic             push_req,
    input logic             push_ack,
    input logic             act_valid,
    input logic [2:0]       act_code,
    input logic [SET_W-1:0] act_set,
    input logic             half_mode
);
    logic accepted;
    assign accepted = req_valid && !busy && !rst;

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd_data & ~CTL_KEEP_MASK) == 32'd0);

    p_disabled_bypass_r3: assert property (@(posedge clk) disable iff (rst)
        $past(accepted) && !$past(ctl_rd_data[B_ENABLE]) |-> act_code == 3'd3);

    p_no_push_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        !ctl_rd_data[B_ENABLE] && !busy |=> !push_req);

    p_locked_miss_r4: assert property (@(posedge clk) disable iff (rst)
        accepted && ctl_rd_data[B_ENABLE] && (req_atomic || bus_lock) && !lookup_hit
        |=> act_valid && act_code == 3'd3);

    p_push_hold_r6: assert property (@(posedge clk) disable iff (rst)
        push_req && !push_ack |=> push_req && !act_valid);

    p_push_done_r6: assert property (@(posedge clk) disable iff (rst)
        push_req && push_ack |=> act_valid && act_code == 3'd3 && !push_req);

    p_half_set_r9: assert property (@(posedge clk) disable iff (rst)
        $past(accepted) && $past(half_mode) |-> act_set[SET_W-1] == 1'b0);

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        accepted |=> act_valid);

    p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        act_valid && !push_req |=> !act_valid || $past(accepted));
endmodule

bind dcache_policy_ctl dcp_checker #(.SET_W(SET_W)) u_chk (
    .clk(clk), .rst(rst), .ctl_rd_data(ctl_rd_data), .req_valid(req_valid),
    .req_atomic(req_atomic), .bus_lock(bus_lock), .lookup_hit(lookup_hit),
    .busy(busy), .push_req(push_req), .push_ack(push_ack),
    .act_valid(act_valid), .act_code(act_code), .act_set(act_set),
    .half_mode(half_mode)
);

// File: tb/tb_dcache_policy_ctl.sv
module tb_dcache_policy_ctl;
    localparam int SET_W = 7;
    localparam logic [31:0] KEEP = 32'hF8E0_E000;

    logic clk = 0;
    logic rst = 1;
    logic ctl_wr_en = 0;
    logic [31:0] ctl_wr_data = 0;
    logic [31:0] ctl_rd_data;
    logic req_valid = 0, req_write = 0, req_atomic = 0, bus_lock = 0;
    logic req_cacheable = 0, lookup_hit = 0, lookup_dirty = 0;
    logic [SET_W-1:0] req_set = 0;
    logic busy, push_req, push_ack = 0, act_valid;
    logic [2:0] act_code;
    logic [SET_W-1:0] act_set;
    logic push_keep_valid, half_mode;

    int vectors = 0, errors = 0;
    logic [31:0] model_ctl = 0;
    logic [2+SET_W:0] sb[$];
    string tags[$];
    bit done = 0;

    always #2 clk = ~clk;

    dcache_policy_ctl #(.SET_W(SET_W)) dut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr_ctl(input logic [31:0] d);
        @(posedge clk); #1;
        ctl_wr_en = 1; ctl_wr_data = d;
        @(posedge clk); #1;
        ctl_wr_en = 0;
        model_ctl = d & KEEP;
        chk("R2 ctl readback", ctl_rd_data, model_ctl);
        chk("R8 keep_valid", {31'd0, push_keep_valid}, {31'd0, model_ctl[28]});
        chk("R9 half_mode", {31'd0, half_mode}, {31'd0, model_ctl[27]});
    endtask

    task automatic issue(input string tag, input logic w, input logic at, input logic bl,
                         input logic cach, input logic hit, input logic dirty,
                         input logic [SET_W-1:0] s);
        logic [2:0] c;
        logic [SET_W-1:0] es;
        es = model_ctl[27] ? (s & ~(SET_W'(1) << (SET_W-1))) : s;
        if (!model_ctl[31]) c = 3;
        else if (at || bl) c = !hit ? 3'd3 : (dirty ? 3'd5 : 3'd4);
        else if (!cach) c = 3;
        else if (hit) c = 0;
        else c = model_ctl[30] ? 3'd2 : 3'd1;
        sb.push_back({c, es}); tags.push_back(tag);
        if (c == 5) begin sb.push_back({3'd3, es}); tags.push_back({tag, " bypass"}); end
        @(posedge clk); #1;
        req_valid = 1; req_write = w; req_atomic = at; bus_lock = bl;
        req_cacheable = cach; lookup_hit = hit; lookup_dirty = dirty; req_set = s;
        @(posedge clk); #1;
        req_valid = 0; req_atomic = 0; bus_lock = 0;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && act_valid) begin
                if (sb.size() == 0) begin
                    vectors++; errors++;
                    $display("FAIL R10 unexpected action got=%0d exp=none", act_code);
                end else begin
                    logic [2+SET_W:0] e;
                    string t;
                    e = sb.pop_front(); t = tags.pop_front();
                    chk({t, " code"}, {29'd0, act_code}, {29'd0, e[2+SET_W:SET_W]});
                    chk({t, " set"}, {25'd0, act_set}, {25'd0, e[SET_W-1:0]});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++; errors++;
            $display("FAIL watchdog got=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 ctl reset", ctl_rd_data, 0);
        chk("R1 idle", {29'd0, act_valid, push_req, busy}, 0);

        wr_ctl(32'hFFFF_FFFF);
        wr_ctl(32'h0);
        // disabled: everything bypasses, no push (R3)
        issue("R3 dis dirty lock", 0, 1, 0, 1, 1, 1, 7'h11);
        issue("R3 dis miss", 1, 0, 0, 1, 0, 0, 7'h45);
        @(negedge clk);
        chk("R3 no push", {31'd0, push_req}, 0);

        wr_ctl(32'h8000_0000);
        issue("R7 alloc read", 0, 0, 0, 1, 0, 0, 7'h7F);
        issue("R7 hit", 1, 0, 0, 1, 1, 1, 7'h03);
        issue("R7 inhibited", 0, 0, 0, 0, 0, 0, 7'h12);
        issue("R4 atomic miss", 1, 1, 0, 1, 0, 0, 7'h21);
        issue("R4 buslock miss inh", 0, 0, 1, 0, 0, 0, 7'h22);
        issue("R5 lock clean hit", 0, 1, 0, 1, 1, 0, 7'h55);
        issue("R5 buslock clean hit", 1, 0, 1, 1, 1, 0, 7'h56);

        wr_ctl(32'hC000_0000);
        issue("R7 noalloc write", 1, 0, 0, 1, 0, 0, 7'h66);
        issue("R4 lock miss nad", 0, 1, 0, 1, 0, 0, 7'h67);

        // push wait (R6)
        wr_ctl(32'h9800_0000);
        issue("R6 push inval", 1, 1, 0, 1, 1, 1, 7'h70);
        repeat (3) @(negedge clk);
        chk("R6 push_req held", {30'd0, push_req, busy}, 3);
        // request during wait must be ignored
        @(posedge clk); #1;
        req_valid = 1; req_atomic = 0; req_cacheable = 1; lookup_hit = 0; req_set = 7'h01;
        @(posedge clk); #1;
        req_valid = 0;
        repeat (2) @(posedge clk); #1;
        push_ack = 1;
        @(posedge clk); #1;
        push_ack = 0;
        @(negedge clk);
        chk("R6 push released", {30'd0, push_req, busy}, 0);
        chk("R9 half set", {31'd0, half_mode}, 1);
        issue("R9 half alloc", 0, 0, 0, 1, 0, 0, 7'h7E);

        wr_ctl(32'hFFFF_FFFF);
        wr_ctl(32'h8000_0000);
        issue("R9 full alloc", 0, 0, 0, 1, 0, 0, 7'h7E);

        repeat (4) @(posedge clk);
        chk("R10 scoreboard drained", sb.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule